// File: doc/BRIEF.md
# External Interrupt Sense Converter

The block sits between a set of external interrupt request pins and a main interrupt controller that only accepts active-high level requests. Each external line can be configured independently to respond to a rising edge, a falling edge, a high level or a low level. Whatever the configured sense, the block presents that line to the parent controller as an active-high level that stays asserted while the request is pending and unmasked.

Every pin first passes through a synchroniser. In level mode the request follows the polarity-adjusted pin. In edge mode a detected edge sets a sticky latch, and only a software write-one-to-clear removes it. Edges keep latching while a line is masked, so software can discard stale events before it opens the line. A small register port with a one-cycle read latency holds the mask, the clear strobe, the polarity and the edge/level selection, and reports the pre-mask request vector.

Top module: `ext_irq_conv`

## Requirements
- R1: After reset every line is masked (mask register all ones), polarity is all ones, edge select is all zeros, all edge latches are clear and `irq_out` is all zeros.
- R2: Register byte offsets are 0x00 mask, 0x04 request clear (reads as zero), 0x08 polarity, 0x0C raw request status (read-only), 0x10 edge select; unmapped offsets read zero. `rdata` carries the addressed value on the cycle after `rd_en` and holds its value when no read is made.
- R3: A line with edge-select bit 0 is level sensed: its raw request is the synchronised pin when its polarity bit is 1 and the inverted pin when it is 0, and it is not sticky.
- R4: A line with edge-select bit 1 is edge sensed: a rising edge (polarity 1) or a falling edge (polarity 0) sets a latch that stays set until cleared; no other pin change sets it.
- R5: Writing offset 0x04 clears the latch of every line whose data bit is 1; lines whose data bit is 0 keep their latch.
- R6: A mask bit of 1 blocks that line at `irq_out`; the raw status is unaffected by the mask, and edges keep latching while masked.
- R7: `irq_out` equals the raw request ANDed with the inverted mask, registered once. A pin change set up before a clock edge shows at `irq_out` after the third rising edge in level mode and after the fourth in edge mode.
- R8: When a clear write and a new edge on the same line fall in the same cycle, the latch ends up set.
- R9: A write to the raw status offset changes no register and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | NUM_LINES | External request pins, asynchronous |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 5 | Register byte offset |
| wdata | input | NUM_LINES | Write data, one bit per line |
| rdata | output | NUM_LINES | Read data, valid the cycle after `rd_en` |
| irq_out | output | NUM_LINES | Active-high level requests toward the parent controller |

## Verification
The contested cycle is the one in which a software clear of a line and a freshly detected edge on that same line both update the latch. The bench raises an edge-mode pin and times a clear write so that it is sampled on exactly the rising edge where the synchronised value first differs from its delayed copy; it then reads the raw status and expects the bit to remain set. A second clear one cycle later must remove it, which shows the first outcome came from the collision rule and not from a dead clear.

// File: rtl/eic_pkg.sv
package eic_pkg;

    localparam int EIC_ADDR_W = 5;

    localparam logic [EIC_ADDR_W-1:0] OFS_BLOCK = 5'h00;
    localparam logic [EIC_ADDR_W-1:0] OFS_DROP  = 5'h04;
    localparam logic [EIC_ADDR_W-1:0] OFS_POL   = 5'h08;
    localparam logic [EIC_ADDR_W-1:0] OFS_RAW   = 5'h0C;
    localparam logic [EIC_ADDR_W-1:0] OFS_MODE  = 5'h10;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_BLOCK,
        SEL_DROP,
        SEL_POL,
        SEL_RAW,
        SEL_MODE
    } reg_sel_e;

    function automatic reg_sel_e decode_sel(input logic [EIC_ADDR_W-1:0] a);
        case (a)
            OFS_BLOCK: return SEL_BLOCK;
            OFS_DROP:  return SEL_DROP;
            OFS_POL:   return SEL_POL;
            OFS_RAW:   return SEL_RAW;
            OFS_MODE:  return SEL_MODE;
            default:   return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/eic_sync.sv
module eic_sync #(
    parameter int N      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pin_i,
    output logic [N-1:0] now_o,
    output logic [N-1:0] before_o
);
    localparam int LAST = STAGES - 1;

    typedef struct packed {
        logic [STAGES-1:0][N-1:0] stg;
        logic [N-1:0]             prev;
    } sync_t;

    sync_t st_q, st_d;

    always_comb begin
        st_d        = st_q;
        st_d.stg[0] = pin_i;
        for (int i = 1; i < STAGES; i++) begin
            st_d.stg[i] = st_q.stg[i-1];
        end
        st_d.prev = st_q.stg[LAST];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign now_o    = st_q.stg[LAST];
    assign before_o = st_q.prev;

    initial begin
        if (STAGES < 2) $error("eic_sync needs at least two stages");
    end

endmodule

// File: rtl/eic_sense.sv
module eic_sense #(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] now_i,
    input  logic [N-1:0] before_i,
    input  logic [N-1:0] pol_i,
    input  logic [N-1:0] mode_i,
    input  logic [N-1:0] drop_i,
    output logic [N-1:0] raw_o
);
    typedef struct packed {
        logic [N-1:0] held;
    } sense_t;

    sense_t st_q, st_d;
    logic [N-1:0] lvl;
    logic [N-1:0] hit;

    for (genvar g = 0; g < N; g++) begin : g_line
        always_comb begin
            lvl[g] = pol_i[g] ? now_i[g] : ~now_i[g];
            hit[g] = mode_i[g] & (pol_i[g] ? (now_i[g] & ~before_i[g])
                                           : (~now_i[g] & before_i[g]));
            raw_o[g] = mode_i[g] ? st_q.held[g] : lvl[g];
        end
    end

    always_comb begin
        st_d      = st_q;
        st_d.held = (st_q.held & ~drop_i) | hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_HELD_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(st_q.held) & ~$past(drop_i)) & ~st_q.held) == '0); // R4

    AST_HELD_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.held & ~$past(st_q.held)) & ~$past(hit)) == '0); // R4

    AST_EDGE_BEATS_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(drop_i) & $past(hit)) & ~st_q.held) == '0); // R8

endmodule

// File: rtl/eic_regs.sv
module eic_regs
    import eic_pkg::*;
#(
    parameter int N = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic                  rd_en,
    input  logic [EIC_ADDR_W-1:0] addr,
    input  logic [N-1:0]          wdata,
    input  logic [N-1:0]          raw_i,
    output logic [N-1:0]          block_o,
    output logic [N-1:0]          pol_o,
    output logic [N-1:0]          mode_o,
    output logic [N-1:0]          drop_o,
    output logic [N-1:0]          rdata_o
);
    typedef struct packed {
        logic [N-1:0] block;
        logic [N-1:0] pol;
        logic [N-1:0] mode;
        logic [N-1:0] rdata;
    } regs_t;

    regs_t    st_q, st_d;
    reg_sel_e sel;

    always_comb begin
        sel    = decode_sel(addr);
        st_d   = st_q;
        drop_o = '0;
        if (wr_en) begin
            case (sel)
                SEL_BLOCK: st_d.block = wdata;
                SEL_DROP:  drop_o     = wdata;
                SEL_POL:   st_d.pol   = wdata;
                SEL_MODE:  st_d.mode  = wdata;
                default:   ;
            endcase
        end
        if (rd_en) begin
            case (sel)
                SEL_BLOCK: st_d.rdata = st_q.block;
                SEL_POL:   st_d.rdata = st_q.pol;
                SEL_RAW:   st_d.rdata = raw_i;
                SEL_MODE:  st_d.rdata = st_q.mode;
                default:   st_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.block <= '1;
            st_q.pol   <= '1;
            st_q.mode  <= '0;
            st_q.rdata <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign block_o = st_q.block;
    assign pol_o   = st_q.pol;
    assign mode_o  = st_q.mode;
    assign rdata_o = st_q.rdata;

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata_o)); // R2

    AST_CFG_WRITE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(block_o) && $stable(pol_o) && $stable(mode_o))); // R9

endmodule

// File: rtl/ext_irq_conv.sv
module ext_irq_conv
    import eic_pkg::*;
#(
    parameter int NUM_LINES   = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_LINES-1:0]  irq_in,
    input  logic                  wr_en,
    input  logic                  rd_en,
    input  logic [EIC_ADDR_W-1:0] addr,
    input  logic [NUM_LINES-1:0]  wdata,
    output logic [NUM_LINES-1:0]  rdata,
    output logic [NUM_LINES-1:0]  irq_out
);
    typedef struct packed {
        logic [NUM_LINES-1:0] req;
    } top_t;

    top_t st_q, st_d;

    logic [NUM_LINES-1:0] pin_now, pin_before;
    logic [NUM_LINES-1:0] raw, block, pol, mode, drop;

    eic_sync #(.N(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_i    (irq_in),
        .now_o    (pin_now),
        .before_o (pin_before)
    );

    eic_sense #(.N(NUM_LINES)) u_sense (
        .clk      (clk),
        .rst_n    (rst_n),
        .now_i    (pin_now),
        .before_i (pin_before),
        .pol_i    (pol),
        .mode_i   (mode),
        .drop_i   (drop),
        .raw_o    (raw)
    );

    eic_regs #(.N(NUM_LINES)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .addr    (addr),
        .wdata   (wdata),
        .raw_i   (raw),
        .block_o (block),
        .pol_o   (pol),
        .mode_o  (mode),
        .drop_o  (drop),
        .rdata_o (rdata)
    );

    always_comb begin
        st_d     = st_q;
        st_d.req = raw & ~block;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_out = st_q.req;

    AST_OUT_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_out & $past(block)) == '0); // R6

    AST_OUT_NEEDS_RAW: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_out & ~$past(raw)) == '0); // R7

endmodule

// File: tb/ext_irq_conv_test.sv
module ext_irq_conv_test;
    localparam int N = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] irq_in = '0;
    logic         wr_en = 1'b0;
    logic         rd_en = 1'b0;
    logic [4:0]   addr = '0;
    logic [N-1:0] wdata = '0;
    logic [N-1:0] rdata;
    logic [N-1:0] irq_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [N-1:0] pol_m, mode_m, blk_m, held_m, in_m;

    always #2 clk = ~clk;

    ext_irq_conv uut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq_out(irq_out)
    );

    function automatic logic [N-1:0] raw_m();
        return (mode_m & held_m) | (~mode_m & ~(in_m ^ pol_m));
    endfunction

    task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [N-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [N-1:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    task automatic drive(input logic [N-1:0] v);
        held_m |= mode_m & ((pol_m & ~in_m & v) | (~pol_m & in_m & ~v));
        in_m = v;
        @(negedge clk);
        irq_in = v;
        repeat (6) @(negedge clk);
    endtask

    task automatic check_state(input string tag);
        logic [N-1:0] r;
        chk({tag, " irq_out"}, irq_out, raw_m() & ~blk_m);
        rd(5'h0C, r);
        chk({tag, " raw"}, r, raw_m());
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [N-1:0] r;
        logic [N-1:0] v;
        pol_m = '1; mode_m = '0; blk_m = '1; held_m = '0; in_m = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1 irq_out", irq_out, '0);
        rd(5'h00, r); chk("R1 mask", r, '1);
        rd(5'h08, r); chk("R1 polarity", r, '1);
        rd(5'h10, r); chk("R1 edge select", r, '0);
        rd(5'h0C, r); chk("R1 raw", r, '0);
        // R2: clear offset and unmapped offset read zero
        rd(5'h04, r); chk("R2 clear reads zero", r, '0);
        rd(5'h14, r); chk("R2 unmapped reads zero", r, '0);

        // line i sense: bit0 of i -> polarity, bit1 of i -> edge select
        pol_m = 32'hAAAA_AAAA; mode_m = 32'hCCCC_CCCC;
        wr(5'h08, pol_m); wr(5'h10, mode_m);
        rd(5'h08, r); chk("R2 polarity readback", r, pol_m);
        rd(5'h10, r); chk("R2 edge readback", r, mode_m);
        wr(5'h04, '1); held_m = '0;
        settle();
        check_state("R6 masked, low-level lines raw only");

        blk_m = '0; wr(5'h00, blk_m); settle();
        check_state("R7 unmasked");

        // R3 R4 R5 R6 sweep over pseudo-random input vectors
        v = 32'h1234_5678;
        for (int s = 0; s < 40; s++) begin
            v = v * 32'd1103515245 + 32'd12345;
            drive(v);
            check_state("R3 R4 sweep");
            if (s % 4 == 3) begin
                wr(5'h04, v ^ 32'h0F0F_0F0F);
                held_m &= ~(v ^ 32'h0F0F_0F0F);
                settle();
                check_state("R5 partial clear");
            end
            if (s % 6 == 5) begin
                blk_m = {v[15:0], v[31:16]};
                wr(5'h00, blk_m); settle();
                check_state("R6 mask change");
            end
            if (s == 20) begin
                pol_m = ~pol_m;
                wr(5'h08, pol_m); settle();
                check_state("R3 polarity swap");
            end
        end

        // R9: write to raw status offset changes nothing
        v = raw_m();
        wr(5'h0C, ~v); settle();
        rd(5'h0C, r); chk("R9 raw after write", r, v);
        rd(5'h00, r); chk("R9 mask after write", r, blk_m);
        rd(5'h08, r); chk("R9 polarity after write", r, pol_m);
        chk("R9 irq_out after write", irq_out, v & ~blk_m);

        // R7 latency, level mode on line 0
        pol_m = '1; mode_m = '0; blk_m = '0;
        wr(5'h08, pol_m); wr(5'h10, mode_m); wr(5'h00, blk_m);
        drive('0); wr(5'h04, '1); held_m = '0; settle();
        @(negedge clk); irq_in = 32'h1;
        repeat (2) @(negedge clk);
        chk("R7 level after two edges", irq_out & 32'h1, '0);
        @(negedge clk);
        chk("R7 level after three edges", irq_out & 32'h1, 32'h1);
        irq_in = '0; in_m = '0; settle();

        // R7 latency, edge mode on line 0
        mode_m = 32'h1; wr(5'h10, mode_m); wr(5'h04, '1); held_m = '0; settle();
        @(negedge clk); irq_in = 32'h1;
        repeat (3) @(negedge clk);
        chk("R7 edge after three edges", irq_out & 32'h1, '0);
        @(negedge clk);
        chk("R7 edge after four edges", irq_out & 32'h1, 32'h1);
        in_m = 32'h1; held_m = 32'h1; settle();

        // R8: clear and new edge in the same cycle
        drive('0); wr(5'h04, '1); held_m = '0; settle();
        @(negedge clk); irq_in = 32'h1;
        repeat (2) @(negedge clk);
        wr_en = 1'b1; addr = 5'h04; wdata = 32'h1;
        @(negedge clk); wr_en = 1'b0;
        rd(5'h0C, r); chk("R8 edge wins over clear", r & 32'h1, 32'h1);
        wr(5'h04, 32'h1); settle();
        rd(5'h0C, r); chk("R5 later clear removes latch", r & 32'h1, '0);
        in_m = 32'h1; held_m = '0;

        // R6: latching continues while masked
        blk_m = 32'h1; wr(5'h00, blk_m);
        drive('0); drive(32'h1);
        chk("R6 masked output", irq_out & 32'h1, '0);
        rd(5'h0C, r); chk("R6 latched while masked", r & 32'h1, 32'h1);
        wr(5'h04, 32'h1); held_m = '0;
        blk_m = '0; wr(5'h00, blk_m); settle();
        chk("R6 stale event cleared before unmask", irq_out & 32'h1, '0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule